// File: doc/BRIEF.md
# Codec control-word serial writer

This block writes one 16-bit control word into one of two audio converter devices over a three-wire serial link. The two devices share the serial clock and the serial data line, and each has its own active-low select. A host raises a one-cycle start request together with a chip index, a 5-bit register number and an 8-bit value. The block builds the word, shifts it out most significant bit first in slow, timed bit cells, and then puts every line back to its idle high level.

Every change on the link lines is followed by a hold time of `WAIT_CYC` clock cycles, so a device with slow setup and hold needs can be served directly from a fast core clock. While a word is in flight, `busy` is high and further requests are dropped. A single-cycle `done` marks completion. A request whose chip index is out of range starts nothing and raises a one-cycle error pulse.

Top module: `codec_ctl_serial_writer`

## Requirements
- R1: The transmitted word is {2'b10, 1'b1, reg[4:0], data[7:0]}: bits 15:14 are binary 10, bit 13 is 1, bits 12:8 are the register number and bits 7:0 are the value.
- R2: The word goes out most significant bit first, bit 15 down to bit 0, with exactly 16 rising edges of the serial clock per transfer.
- R3: Each bit cell drives the clock low, then places the bit on the data line, then drives the clock high. The data line changes only while the clock is low and a select is active, so the receiver can capture on the rising edge.
- R4: On acceptance all four lines are high, and they stay high for one wait interval before the chosen select falls. A select falls only while clock and data are high.
- R5: Chip index 0 drives `cs0_n` low. Indices 1, 2 and 3 drive `cs1_n` low. The other select stays high, and the two selects are never low together.
- R6: After the last bit's clock-high phase, clock, data and both selects go high on the same cycle and are held for one wait interval before completion.
- R7: Every phase lasts exactly `WAIT_CYC` cycles, so no two line changes are closer than `WAIT_CYC` cycles, and `busy` is high for exactly 51 × `WAIT_CYC` cycles per transfer.
- R8: A start request while `busy` is high is ignored: the word, the select used and the transfer length are unchanged, and no second transfer follows.
- R9: `done` is high for one cycle, on the first cycle `busy` is low after the final idle hold.
- R10: A start request with chip index 4 or more, made while idle, starts no transfer and leaves all lines high. `err` is high for exactly the next cycle.
- R11: While reset is low, the four link lines are high and `busy`, `done` and `err` are low. This also holds when reset arrives in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle transfer request |
| chip_i | input | 3 | Target chip index (0..3 valid) |
| reg_i | input | 5 | Register number placed in the word |
| data_i | input | 8 | Value placed in the word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a rejected chip index |
| sclk_o | output | 1 | Shared serial clock, idle high |
| sdata_o | output | 1 | Shared serial data, idle high |
| cs0_n_o | output | 1 | Active-low select of chip 0 |
| cs1_n_o | output | 1 | Active-low select of chip 1 |

## Verification
The bench builds the block with `WAIT_CYC` = 3 instead of the microsecond-scale default. A full 51-phase transfer then takes about 150 cycles, so several words, an injected mid-transfer request and a mid-transfer reset all fit in a short run. A phase of three cycles still tells exact phase lengths apart from off-by-one errors: the measured minimum gap between line changes must be exactly 3, and the post-frame hold must be exactly one interval. Chip indices 2, 3 (the top of the valid range) and 4, 7 (rejected) cover both sides of the decode boundary.

// File: rtl/cw_pkg.sv
// Package: shared constants, phase encoding and frame packing for the
// codec control-word writer.
// Assumes a fixed 16-bit word: device address, forced write bit, register, value.
package cw_pkg;
    localparam int           DEV_W    = 2;
    localparam logic [1:0]   DEV_ADDR = 2'b10;
    localparam int           REG_W    = 5;
    localparam int           DAT_W    = 8;
    localparam int           FRAME_W  = DEV_W + 1 + REG_W + DAT_W;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_CSON  = 3'd2,
        PH_CLKLO = 3'd3,
        PH_DATA  = 3'd4,
        PH_CLKHI = 3'd5,
        PH_POST  = 3'd6
    } phase_e;

    // Assemble the word that is shifted out MSB first.
    function automatic logic [FRAME_W-1:0] pack_frame(
        input logic [REG_W-1:0] r,
        input logic [DAT_W-1:0] d
    );
        return {DEV_ADDR, 1'b1, r, d};
    endfunction
endpackage

// File: rtl/cw_req_check.sv
// Request check: accepts a start only while idle and only for an in-range
// chip index. Rejected idle requests produce a one-cycle error pulse.
// Assumes start_i is sampled on the rising clock edge.
module cw_req_check #(
    parameter int IDX_W   = 3,
    parameter int MAX_IDX = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] chip_i,
    input  logic             busy_i,
    output logic             accept_o,
    output logic             sel_o,
    output logic             err_o
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(MAX_IDX);

    logic idx_ok;
    logic err_q;

    // Decode whether the request may start and which select it uses.
    always_comb begin
        idx_ok   = (chip_i <= LIMIT);
        accept_o = start_i && !busy_i && idx_ok;
        sel_o    = (chip_i != '0);
    end

    // Register the rejection pulse for an out-of-range idle request.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= start_i && !busy_i && !idx_ok;
    end

    assign err_o = err_q;
endmodule

// File: rtl/cw_phase_timer.sv
// Phase timer: a down-counter reloaded at each phase entry, flagging when
// the current phase has lasted WAIT_CYC cycles.
// Assumes restart_i is pulsed on the edge that enters a new phase.
module cw_phase_timer #(
    parameter int WAIT_CYC = 12500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expire_o
);
    localparam int            CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (restart_i)   cnt_q <= LOAD;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q == '0);

    generate
        if (WAIT_CYC > 1) begin : g_chk
            // R7
            restart_not_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
                restart_i |=> !expire_o);
        end
    endgenerate
endmodule

// File: rtl/cw_frame_shreg.sv
// Frame shift register: loads the word on acceptance and moves the next
// bit into the MSB position on each shift request.
// Assumes load and shift are never requested in the same cycle.
module cw_frame_shreg #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               shift_i,
    output logic               msb_o
);
    logic [FRAME_W-1:0] sh_q;

    // Load the word or shift it left by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh_q <= '0;
        else if (load_i)  sh_q <= frame_i;
        else if (shift_i) sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
    end

    assign msb_o = sh_q[FRAME_W-1];
endmodule

// File: rtl/cw_bit_sequencer.sv
// Bit sequencer: walks the idle hold, select assertion, 16 three-phase
// bit cells and the final idle hold, driving registered link lines.
// Assumes expire_i rises after each phase has lasted its full interval.
module cw_bit_sequencer
    import cw_pkg::*;
#(
    parameter int FRAME_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic       sel_i,
    input  logic       expire_i,
    input  logic       msb_i,
    output logic       restart_o,
    output logic       shift_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       sclk_o,
    output logic       sdata_o,
    output logic [1:0] cs_n_o
);
    localparam int             NUM_CS = 2;
    localparam int             BIT_W  = $clog2(FRAME_W);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(FRAME_W - 1);

    phase_e           ph_q;
    logic [BIT_W-1:0] bit_q;
    logic             sel_q;
    logic             sclk_q;
    logic             sdata_q;
    logic             done_q;
    logic [NUM_CS-1:0] cs_n_q;
    logic             go_cson;
    logic             go_post;

    // Phase-transition strobes shared by the select line flops.
    always_comb begin
        go_cson   = (ph_q == PH_PRE)   && expire_i;
        go_post   = (ph_q == PH_CLKHI) && expire_i && (bit_q == '0);
        shift_o   = (ph_q == PH_CLKHI) && expire_i && (bit_q != '0);
        restart_o = (ph_q == PH_IDLE) ? accept_i : expire_i;
        busy_o    = (ph_q != PH_IDLE);
    end

    // Main phase machine with clock, data and completion registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            bit_q   <= '0;
            sel_q   <= 1'b0;
            sclk_q  <= 1'b1;
            sdata_q <= 1'b1;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                PH_IDLE: if (accept_i) begin
                    ph_q    <= PH_PRE;
                    sel_q   <= sel_i;
                    bit_q   <= LAST;
                    sclk_q  <= 1'b1;
                    sdata_q <= 1'b1;
                end
                PH_PRE: if (expire_i) ph_q <= PH_CSON;
                PH_CSON: if (expire_i) begin
                    ph_q   <= PH_CLKLO;
                    sclk_q <= 1'b0;
                end
                PH_CLKLO: if (expire_i) begin
                    ph_q    <= PH_DATA;
                    sdata_q <= msb_i;
                end
                PH_DATA: if (expire_i) begin
                    ph_q   <= PH_CLKHI;
                    sclk_q <= 1'b1;
                end
                PH_CLKHI: if (expire_i) begin
                    if (bit_q == '0) begin
                        ph_q    <= PH_POST;
                        sclk_q  <= 1'b1;
                        sdata_q <= 1'b1;
                    end else begin
                        ph_q   <= PH_CLKLO;
                        sclk_q <= 1'b0;
                        bit_q  <= bit_q - 1'b1;
                    end
                end
                PH_POST: if (expire_i) begin
                    ph_q   <= PH_IDLE;
                    done_q <= 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
            // Select line i: falls on select phase entry when chosen, rises at frame end.
            always_ff @(posedge clk) begin
                if (!rst_n)                            cs_n_q[i] <= 1'b1;
                else if (go_cson && (sel_q == 1'(i)))  cs_n_q[i] <= 1'b0;
                else if (go_post)                      cs_n_q[i] <= 1'b1;
            end

            // R4
            cs_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(cs_n_q[i]) |-> (sclk_q && sdata_q));
        end
    endgenerate

    assign sclk_o  = sclk_q;
    assign sdata_o = sdata_q;
    assign cs_n_o  = cs_n_q;
    assign done_o  = done_q;

    // R3
    data_move_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~&cs_n_q) && $past(~&cs_n_q) && (sdata_q != $past(sdata_q)))
            |-> (!sclk_q && !$past(sclk_q)));

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_o && $past(busy_o)));

    // R6
    frame_end_all_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q[0] & cs_n_q[1]) |-> (sclk_q && sdata_q));
endmodule

// File: rtl/codec_ctl_serial_writer.sv
// Top: codec control-word serial writer. Joins request check, phase timer,
// frame shift register and bit sequencer.
// Assumes a single clock domain and a synchronous active-low reset.
module codec_ctl_serial_writer
    import cw_pkg::*;
#(
    parameter int WAIT_CYC = 12500,
    parameter int IDX_W    = 3,
    parameter int MAX_IDX  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] chip_i,
    input  logic [REG_W-1:0] reg_i,
    input  logic [DAT_W-1:0] data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic             sclk_o,
    output logic             sdata_o,
    output logic             cs0_n_o,
    output logic             cs1_n_o
);
    logic               accept;
    logic               sel;
    logic               busy;
    logic               restart;
    logic               expire;
    logic               shift;
    logic               msb;
    logic [1:0]         cs_n;
    logic [FRAME_W-1:0] frame;

    // Build the outgoing word from the request fields.
    always_comb frame = pack_frame(reg_i, data_i);

    cw_req_check #(.IDX_W(IDX_W), .MAX_IDX(MAX_IDX)) u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .chip_i   (chip_i),
        .busy_i   (busy),
        .accept_o (accept),
        .sel_o    (sel),
        .err_o    (err_o)
    );

    cw_phase_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .expire_o  (expire)
    );

    cw_frame_shreg #(.FRAME_W(FRAME_W)) u_shreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .frame_i (frame),
        .shift_i (shift),
        .msb_o   (msb)
    );

    cw_bit_sequencer #(.FRAME_W(FRAME_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .sel_i     (sel),
        .expire_i  (expire),
        .msb_i     (msb),
        .restart_o (restart),
        .shift_o   (shift),
        .busy_o    (busy),
        .done_o    (done_o),
        .sclk_o    (sclk_o),
        .sdata_o   (sdata_o),
        .cs_n_o    (cs_n)
    );

    assign busy_o  = busy;
    assign cs0_n_o = cs_n[0];
    assign cs1_n_o = cs_n[1];

    // R5
    cs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n_o || cs1_n_o));

    // R10
    err_no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && cs0_n_o && cs1_n_o));
endmodule

// File: tb/tb_codec_ctl_serial_writer.sv
module tb_codec_ctl_serial_writer;
    localparam int W = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chip = '0;
    logic [4:0] rgs = '0;
    logic [7:0] dat = '0;
    logic       busy, done, err, sclk, sdata, cs0_n, cs1_n;

    int checks = 0;
    int fails  = 0;

    // measurements from the last transfer
    logic [15:0] m_frame;
    int          m_nbits, m_busy, m_min, m_post;
    bit          m_cs0, m_cs1, m_end, m_done_seen;

    // {chip, reg, data, expected word, expected select one-hot {cs1,cs0}}
    localparam logic [33:0] VECS [5] = '{
        {3'd0, 5'h02, 8'h5A, 16'hA25A, 2'b01},
        {3'd1, 5'h1F, 8'hFF, 16'hBFFF, 2'b10},
        {3'd2, 5'h00, 8'h00, 16'hA000, 2'b10},
        {3'd3, 5'h15, 8'hA5, 16'hB5A5, 2'b10},
        {3'd0, 5'h0A, 8'h81, 16'hAA81, 2'b01}
    };

    codec_ctl_serial_writer #(.WAIT_CYC(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chip_i(chip),
        .reg_i(rgs), .data_i(dat), .busy_o(busy), .done_o(done), .err_o(err),
        .sclk_o(sclk), .sdata_o(sdata), .cs0_n_o(cs0_n), .cs1_n_o(cs1_n)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [2:0] c, input logic [4:0] r,
                            input logic [7:0] d, input bit inject);
        logic [3:0] prev, cur;
        int gap;
        @(negedge clk);
        start = 1'b1; chip = c; rgs = r; dat = d;
        @(negedge clk);
        start = 1'b0;
        m_frame = '0; m_nbits = 0; m_busy = 0; m_min = 1000; m_post = 0;
        m_cs0 = 0; m_cs1 = 0; m_end = 0; m_done_seen = 0;
        prev = 4'b1111; gap = 0;
        for (int k = 0; k < 51 * W + 20 && !m_done_seen; k++) begin
            if (k > 0) @(negedge clk);
            cur = {sclk, sdata, cs1_n, cs0_n};
            if (busy) m_busy++;
            if (cur != prev) begin
                if (gap < m_min) m_min = gap;
                gap = 1;
            end else gap++;
            if (!prev[3] && cur[3]) begin
                m_frame = {m_frame[14:0], sdata};
                m_nbits++;
            end
            if (!cs0_n) m_cs0 = 1;
            if (!cs1_n) m_cs1 = 1;
            if (inject && k == 10 * W) begin
                start = 1'b1; chip = (c == 3'd0) ? 3'd1 : 3'd0; rgs = ~r; dat = ~d;
            end else start = 1'b0;
            if (done) begin
                m_done_seen = 1;
                m_end  = (cur == 4'b1111) && !busy;
                m_post = gap;
            end
            prev = cur;
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R11: reset state
        repeat (3) @(negedge clk);
        chk({sclk, sdata, cs1_n, cs0_n} == 4'b1111, "R11 reset lines", {sclk, sdata, cs1_n, cs0_n}, 4'hF);
        chk({busy, done, err} == 3'b000, "R11 reset flags", {busy, done, err}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table-driven transfers
        for (int i = 0; i < 5; i++) begin
            run_xfer(VECS[i][33:31], VECS[i][30:26], VECS[i][25:18], 1'b0);
            chk(m_done_seen, "R9 done seen", m_done_seen, 1);
            chk(m_frame == VECS[i][17:2], "R1 word", m_frame, VECS[i][17:2]);
            chk(m_nbits == 16, "R2 rising edges", m_nbits, 16);
            chk({m_cs1, m_cs0} == VECS[i][1:0], "R5 select", {m_cs1, m_cs0}, VECS[i][1:0]);
            chk(m_busy == 51 * W, "R7 busy length", m_busy, 51 * W);
            chk(m_min == W, "R3 R4 min phase gap", m_min, W);
            chk(m_end, "R6 lines high at done", m_end, 1);
            chk(m_post == W + 1, "R6 final hold", m_post, W + 1);
            @(negedge clk);
            chk(!done, "R9 done one cycle", done, 0);
        end

        // R8: start while busy is ignored
        run_xfer(3'd1, 5'h13, 8'h3C, 1'b1);
        chk(m_frame == 16'hB33C, "R8 word kept", m_frame, 16'hB33C);
        chk({m_cs1, m_cs0} == 2'b10, "R8 select kept", {m_cs1, m_cs0}, 2);
        chk(m_busy == 51 * W, "R8 length kept", m_busy, 51 * W);
        repeat (3) @(negedge clk);
        chk(!busy && cs0_n && cs1_n, "R8 no second transfer", busy, 0);

        // R10: out-of-range chip index, both sides of boundary
        for (int j = 0; j < 2; j++) begin
            @(negedge clk);
            start = 1'b1; chip = (j == 0) ? 3'd4 : 3'd7;
            @(negedge clk);
            start = 1'b0;
            chk(err && !busy, "R10 err pulse", {err, busy}, 2);
            @(negedge clk);
            chk(!err && !busy, "R10 err one cycle", {err, busy}, 0);
            chk({sclk, sdata, cs1_n, cs0_n} == 4'b1111, "R10 lines idle", {sclk, sdata, cs1_n, cs0_n}, 4'hF);
        end

        // R11: reset in the middle of a transfer
        @(negedge clk);
        start = 1'b1; chip = 3'd1; rgs = 5'h07; dat = 8'h00;
        @(negedge clk);
        start = 1'b0;
        repeat (7 * W) @(negedge clk);
        chk(!cs1_n && busy, "R11 mid transfer active", {cs1_n, busy}, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk({sclk, sdata, cs1_n, cs0_n} == 4'b1111, "R11 mid reset lines", {sclk, sdata, cs1_n, cs0_n}, 4'hF);
        chk({busy, done, err} == 3'b000, "R11 mid reset flags", {busy, done, err}, 0);
        rst_n = 1'b1;

        // transfer after reset still correct
        run_xfer(3'd0, 5'h11, 8'hC3, 1'b0);
        chk(m_frame == 16'hB1C3, "R1 after reset", m_frame, 16'hB1C3);
        chk({m_cs1, m_cs0} == 2'b01, "R5 after reset", {m_cs1, m_cs0}, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule